// File: doc/BRIEF.md
# Partitioned message buffer allocator

This block tracks ownership of a fixed pool of message buffer slots, holding a single busy flag per slot. A client raises an allocation request marked as either receive or transmit. The block answers one cycle later with a slot index, or with a failure flag when no eligible slot is free. A separate release port returns a slot to the pool by its index. The block accepts one request per cycle, and a release may arrive in the same cycle as a request.

The pool is split into two regions. The lowest quarter is kept for receive buffers. The other three quarters are shared. A transmit request may only take slots from the shared region. A receive request may take any slot. Because of this split, outgoing traffic can never use up the slots that incoming responses need. The search always grants the lowest-numbered eligible free slot. The same clock edge that registers the grant also marks that slot busy. The block also outputs a live count of busy slots and two separate failure counters, one for receive and one for transmit.

Top module: `msg_slot_alloc`

## Requirements
- R1: After reset every slot is free, `used_count` is 0, both failure counters are 0 and `grant_valid` is low.
- R2: A receive request (`req_is_tx`=0) grants the lowest-numbered free slot, searching from slot 0.
- R3: A transmit request (`req_is_tx`=1) grants the lowest-numbered free slot at or above index POOL_SIZE/4 (16 with the default POOL_SIZE of 64). Slots below that index are never granted to it.
- R4: The answer to a request sampled on clock edge N appears on `grant_valid`/`grant_fail`/`grant_idx` after edge N, for one cycle. On success, the granted slot is busy from edge N, and `used_count` rises by one when no release lands on the same edge.
- R5: When no eligible slot is free, the answer has `grant_fail`=1 and no busy flag changes.
- R6: A transmit request fails when every slot from POOL_SIZE/4 upward is busy, even if reserved slots are free. A receive request made in that state still succeeds in the reserved quarter.
- R7: A release (`free_valid`=1) clears the busy flag of `free_idx` unconditionally. Releasing a slot that is already free changes nothing.
- R8: When a release and a request arrive in the same cycle, the release is applied first. The released slot is therefore eligible for that same request.
- R9: Each failed receive answer increments `rx_fail_count` by one. Each failed transmit answer increments `tx_fail_count` by one. Both counters saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Allocation request |
| req_is_tx | input | 1 | 1 = transmit request, 0 = receive request |
| free_valid | input | 1 | Release request |
| free_idx | input | $clog2(POOL_SIZE) | Slot to release |
| grant_valid | output | 1 | Answer to the previous cycle's request |
| grant_fail | output | 1 | No eligible slot was free |
| grant_idx | output | $clog2(POOL_SIZE) | Granted slot index |
| used_count | output | $clog2(POOL_SIZE+1) | Number of busy slots |
| rx_fail_count | output | CNT_W | Failed receive requests |
| tx_fail_count | output | CNT_W | Failed transmit requests |

## Verification
The hardest state to reach is a full shared region with the reserved quarter still partly free, because transmit failures and receive successes only diverge there. The stimulus fills slots 16 to 63 with transmit requests, then issues a failing transmit request and a succeeding receive request. It then combines a release with a request on the same slot. It also drains the reserved quarter completely, so that a receive request fails too.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // lowest slot index a request class may search from
  function automatic int unsigned search_base(input logic is_tx, input int unsigned pool);
    return is_tx ? pool / 4 : 0;
  endfunction
endpackage

// File: rtl/slot_search.sv
module slot_search #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  input  logic          is_tx,
  output logic          found,
  output logic [IW-1:0] idx
);
  import alloc_pkg::*;
  int unsigned base;
  always_comb begin
    base  = search_base(is_tx, N);
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i] && (i >= int'(base))) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_flags.sv
module slot_flags #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  output logic [N-1:0]  flags,
  output logic [N-1:0]  flags_post_free
);
  always_comb begin
    flags_post_free = flags;
    if (clr_en) flags_post_free[clr_idx] = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      flags <= flags_post_free;
      if (set_en) flags[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc && (count != {W{1'b1}})) count <= count + 1'b1;
  end
endmodule

// File: rtl/msg_slot_alloc.sv
module msg_slot_alloc #(
  parameter int POOL_SIZE = 64,
  parameter int CNT_W     = 8,
  localparam int IW       = $clog2(POOL_SIZE),
  localparam int UCW      = $clog2(POOL_SIZE + 1),
  localparam int QUARTER  = POOL_SIZE / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_tx,
  input  logic             free_valid,
  input  logic [IW-1:0]    free_idx,
  output logic             grant_valid,
  output logic             grant_fail,
  output logic [IW-1:0]    grant_idx,
  output logic [UCW-1:0]   used_count,
  output logic [CNT_W-1:0] rx_fail_count,
  output logic [CNT_W-1:0] tx_fail_count
);
  function automatic logic [UCW-1:0] busy_total(input logic [POOL_SIZE-1:0] f);
    logic [UCW-1:0] s;
    s = '0;
    for (int i = 0; i < POOL_SIZE; i++) s = s + UCW'(f[i]);
    return s;
  endfunction

  logic [POOL_SIZE-1:0] flags, flags_post_free;
  logic                 srch_found;
  logic [IW-1:0]        srch_idx;
  logic                 alloc_ok;   // grant happens this cycle
  logic                 free_hit;   // release lands on a busy slot
  logic                 resp_tx;
  logic [1:0]           fail_inc;
  logic [CNT_W-1:0]     fail_cnt [2];

  slot_flags #(.N(POOL_SIZE), .IW(IW)) flags_i (
    .clk(clk), .rst_n(rst_n),
    .clr_en(free_valid), .clr_idx(free_idx),
    .set_en(alloc_ok), .set_idx(srch_idx),
    .flags(flags), .flags_post_free(flags_post_free)
  );

  slot_search #(.N(POOL_SIZE), .IW(IW)) search_i (
    .busy(flags_post_free), .is_tx(req_is_tx),
    .found(srch_found), .idx(srch_idx)
  );

  assign alloc_ok   = req_valid && srch_found;
  assign free_hit   = free_valid && flags[free_idx];
  assign used_count = busy_total(flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_fail  <= 1'b0;
      grant_idx   <= '0;
      resp_tx     <= 1'b0;
    end else begin
      grant_valid <= req_valid;
      grant_fail  <= req_valid && !srch_found;
      grant_idx   <= srch_found ? srch_idx : '0;
      resp_tx     <= req_is_tx;
    end
  end

  assign fail_inc[0] = req_valid && !srch_found && !req_is_tx;
  assign fail_inc[1] = req_valid && !srch_found && req_is_tx;

  for (genvar g = 0; g < 2; g++) begin : g_fail
    fail_counter #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .inc(fail_inc[g]), .count(fail_cnt[g])
    );
  end
  assign rx_fail_count = fail_cnt[0];
  assign tx_fail_count = fail_cnt[1];

  // R3: transmit grants stay out of the reserved quarter
  a_r3_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_tx && srch_found) |-> (int'(srch_idx) >= QUARTER));
  // R2: a granted slot was free after the release
  a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> !flags_post_free[srch_idx]);
  // R4: a successful grant adds one busy slot
  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && !free_hit) |=> (used_count == $past(used_count) + 1'b1));
  // R5: a failed request leaves the pool unchanged
  a_r5_fail_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !srch_found && !free_valid) |=> $stable(flags));
  // R7: a release clears the slot unless it is granted again at once
  a_r7_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !(alloc_ok && srch_idx == free_idx)) |=> !flags[$past(free_idx)]);
  // R9: receive failure counter tracks failed receive answers
  a_r9_rx_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_inc[0] && rx_fail_count != {CNT_W{1'b1}}) |=> (rx_fail_count == $past(rx_fail_count) + 1'b1));
endmodule

// File: tb/msg_slot_alloc_tb_top.sv
module msg_slot_alloc_tb_top;
  localparam int N = 64;
  localparam int Q = N / 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_tx = 0, free_valid = 0;
  logic [5:0] free_idx = '0;
  logic grant_valid, grant_fail;
  logic [5:0] grant_idx;
  logic [6:0] used_count;
  logic [7:0] rx_fail_count, tx_fail_count;

  always #5 clk = ~clk;

  msg_slot_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_tx(req_is_tx),
    .free_valid(free_valid), .free_idx(free_idx), .grant_valid(grant_valid),
    .grant_fail(grant_fail), .grant_idx(grant_idx), .used_count(used_count),
    .rx_fail_count(rx_fail_count), .tx_fail_count(tx_fail_count)
  );

  int checks = 0, failures = 0;
  bit model_busy [N];
  int exp_q [$];      // expected index, -1 = failure
  string tag_q [$];
  int exp_rx_fail = 0, exp_tx_fail = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_count();
    int c = 0;
    for (int i = 0; i < N; i++) c += model_busy[i];
    return c;
  endfunction

  // driver: one cycle of stimulus, expected answer pushed to scoreboard
  task automatic op(input bit do_req, input bit tx, input bit do_free, input int fidx, input string tag);
    int e;
    @(negedge clk);
    if (do_free) model_busy[fidx] = 0;
    if (do_req) begin
      e = -1;
      for (int i = (tx ? Q : 0); i < N; i++)
        if (!model_busy[i]) begin e = i; break; end
      if (e >= 0) model_busy[e] = 1;
      else if (tx) exp_tx_fail++; else exp_rx_fail++;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    req_valid = do_req; req_is_tx = tx;
    free_valid = do_free; free_idx = 6'(fidx);
    @(negedge clk);
    req_valid = 0; free_valid = 0;
  endtask

  // monitor: compares answers as they appear
  always @(negedge clk) begin
    if (rst_n && grant_valid) begin
      int e;
      string t;
      if (exp_q.size() == 0) check("R4 unexpected answer", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " fail flag"}, grant_fail, (e < 0));
        if (e >= 0) check({t, " index"}, grant_idx, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 used_count", used_count, 0);
    check("R1 rx_fail_count", rx_fail_count, 0);
    check("R1 tx_fail_count", tx_fail_count, 0);
    check("R1 grant_valid", grant_valid, 0);
    rst_n = 1;
    repeat (3) op(1, 0, 0, 0, "R2 rx from zero");
    repeat (2) op(1, 1, 0, 0, "R3 tx from quarter");
    @(negedge clk);
    check("R4 used_count", used_count, model_count());
    op(0, 0, 1, 1, "R7 free");
    check("R7 used after free", used_count, model_count());
    op(1, 0, 0, 0, "R2 rx reuses freed");
    op(0, 0, 1, 30, "R7 free idle slot");
    check("R7 idle free no effect", used_count, model_count());
    for (int k = 0; k < N - Q - 2; k++) op(1, 1, 0, 0, "R3 tx fill");
    op(1, 1, 0, 0, "R6 tx full region");
    @(negedge clk);
    check("R5 used unchanged on fail", used_count, model_count());
    check("R9 tx_fail_count", tx_fail_count, exp_tx_fail);
    op(1, 0, 0, 0, "R6 rx uses reserved");
    op(1, 1, 1, 20, "R8 free then tx grant");
    check("R8 used_count", used_count, model_count());
    for (int k = 0; k < Q - 4; k++) op(1, 0, 0, 0, "R2 rx fill");
    op(1, 0, 0, 0, "R5 rx pool full");
    op(1, 1, 0, 0, "R5 tx pool full");
    @(negedge clk);
    check("R5 used stays full", used_count, N);
    check("R9 rx_fail_count", rx_fail_count, exp_rx_fail);
    check("R9 tx_fail_count second", tx_fail_count, exp_tx_fail);
    for (int k = 0; k < N; k++) op(0, 0, 1, k, "R7 drain");
    check("R7 all freed", used_count, 0);
    op(1, 1, 0, 0, "R3 tx after drain");
    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule